// File: doc/BRIEF.md
# Indexed Configuration Register Space

This block implements a byte-wide configuration space that a host reaches through two adjacent I/O addresses: an index port and a data port. The host writes a register number to the index port, then reads or writes that register at the data port. A strap input chooses which of two fixed I/O base addresses the pair answers at.

The space has a few global registers: a fixed identification byte, a chip-configuration byte whose bit 0 enables the chip, and a logical-unit select. Register numbers 0x30 and above are banked by the unit select, and three units are implemented, numbered 0x07, 0x0D and 0x0E. Each unit holds an activate byte and a 16-bit runtime I/O base. Unit 0x07 is the GPIO unit. It adds a pin-select byte and two per-pin bytes, one for configuration and one for events. Each of the 32 pins keeps its own copy of both bytes, and the pin-select value decides which pin's copy the data port reaches.

The GPIO unit's runtime base, its activate state and the chip-enable bit are brought out as plain outputs for the decoders next to this block.

Top module: `indexed_cfg_space`

## Requirements
- R1: With `strap_alt` low the index port is I/O address 0x2E and the data port 0x2F. With `strap_alt` high they are 0x4E and 0x4F. A strobe at any other address changes no register and leaves `io_rdata` unchanged.
- R2: The index register is 8 bits wide and resets to 0x00. It keeps its value until the index port is written again, and a read of the index port returns it.
- R3: Register 0x20 returns the identification code: 0xE5 when parameter `VARIANT_ALT` is 0 and 0xE9 when it is 1. Writes to it have no effect.
- R4: Register 0x21 is a read/write byte that resets to 0x01. Its bit 0 drives `chip_en`.
- R5: Register 0x07 is a read/write unit select that resets to 0x00. Accesses to register numbers 0x30 and above reach only the bank of the unit currently selected, and each unit's registers are independent of the other units'.
- R6: In each implemented unit, register 0x30 is a read/write activate byte that resets to 0x00. `gpio_active` is high exactly when the activate byte of unit 0x07 is nonzero.
- R7: In each implemented unit, register 0x60 holds the high byte and register 0x61 the low byte of a 16-bit base. Both reset to 0x00. `gpio_base` shows the base of unit 0x07.
- R8: In unit 0x07, register 0xF0 is the pin select, and pin n (0..31) is written as ((n<<1)&0xF0)|(n&7). The pin number is taken from bits 5:4 (upper two bits) and 2:0 (lower three bits) of the written byte. On readback, bits 7:6 and 3 read as zero.
- R9: In unit 0x07, register 0xF1 (configuration) and register 0xF2 (event) each keep a separate byte for every one of the 32 pins. These bytes reset to 0x00, and the data port reaches the bytes of the pin currently selected.
- R10: A read of an unimplemented register returns 0xFF, and a write to it has no effect. This covers a global number other than 0x07, 0x20 and 0x21 below 0x30, any banked number while an unimplemented unit is selected, and a banked number the selected unit does not have.
- R11: Read data appears on `io_rdata` at the clock edge that samples the read strobe. It holds until the next accepted read, and it resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_alt | input | 1 | Selects the alternate index/data port address pair |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| chip_en | output | 1 | Bit 0 of the chip-configuration register |
| gpio_active | output | 1 | GPIO unit activate byte is nonzero |
| gpio_base | output | 16 | GPIO unit runtime I/O base |

## Verification
The hardest case to reach is the third level of selection. A per-pin byte is only visible after the index, the unit select and the pin select have all been set, and a fault that aliases two pins or two units would still return the value just written. The stimulus therefore writes distinct bytes to pins 0, 13 and 31 and to the base registers of two units. It then moves the selections away and back before reading, and it writes an out-of-range pin-select byte whose masked value must land on pin 31. Address decoding is tested by issuing strobes at the pair the strap did not select and then confirming that neither the index register nor the read data moved.

// File: rtl/cfg_space_pkg.sv
`timescale 1ns/1ps
package cfg_space_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [7:0] IDX_UNIT_SEL = 8'h07;
  localparam logic [7:0] IDX_ID       = 8'h20;
  localparam logic [7:0] IDX_CHIPCFG  = 8'h21;
  localparam logic [7:0] IDX_BANK_LO  = 8'h30;
  localparam logic [7:0] IDX_ACT      = 8'h30;
  localparam logic [7:0] IDX_BASE_HI  = 8'h60;
  localparam logic [7:0] IDX_BASE_LO  = 8'h61;
  localparam logic [7:0] IDX_PIN_SEL  = 8'hF0;
  localparam logic [7:0] IDX_PIN_CFG  = 8'hF1;
  localparam logic [7:0] IDX_PIN_EVT  = 8'hF2;

  localparam logic [7:0] RD_EMPTY     = 8'hFF;
  localparam logic [7:0] CHIPCFG_RST  = 8'h01;

  localparam int         NUM_UNITS = 3;
  localparam int         GPIO_SLOT = 0;

  function automatic logic [7:0] unit_id(input int slot);
    case (slot)
      0:       unit_id = 8'h07;
      1:       unit_id = 8'h0D;
      default: unit_id = 8'h0E;
    endcase
  endfunction

  typedef struct packed {
    logic       en;
    logic [7:0] idx;
    logic [7:0] data;
  } cfg_wr_t;
endpackage

// File: rtl/cfg_port_decode.sv
`timescale 1ns/1ps
module cfg_port_decode
  import cfg_space_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              strap_alt,
  output logic              hit_index,
  output logic              hit_data
);
  logic [ADDR_W-1:0] base_sel;

  always_comb begin
    base_sel  = strap_alt ? BASE_ALT : BASE_PRI;
    hit_index = (io_addr == base_sel);
    hit_data  = (io_addr == base_sel + 16'd1);
  end
endmodule

// File: rtl/cfg_unit_regs.sv
`timescale 1ns/1ps
module cfg_unit_regs
  import cfg_space_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cfg_wr_t     wr,
  input  logic [7:0]  rd_idx,
  output logic [7:0]  act,
  output logic [15:0] base,
  output logic        rd_hit,
  output logic [7:0]  rd_val
);
  logic [7:0] act_q, act_d, hi_q, hi_d, lo_q, lo_d;
  logic       act_en, hi_en, lo_en;

  always_comb begin
    act_en = wr.en && (wr.idx == IDX_ACT);
    hi_en  = wr.en && (wr.idx == IDX_BASE_HI);
    lo_en  = wr.en && (wr.idx == IDX_BASE_LO);
    act_d  = wr.data;
    hi_d   = wr.data;
    lo_d   = wr.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      if (act_en) act_q <= act_d;
      if (hi_en)  hi_q  <= hi_d;
      if (lo_en)  lo_q  <= lo_d;
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = RD_EMPTY;
    case (rd_idx)
      IDX_ACT:     rd_val = act_q;
      IDX_BASE_HI: rd_val = hi_q;
      IDX_BASE_LO: rd_val = lo_q;
      default:     rd_hit = 1'b0;
    endcase
  end

  assign act  = act_q;
  assign base = {hi_q, lo_q};

  // R7: the base only moves on a write aimed at this unit
  p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.en |=> $stable(base));
  // R6: the activate byte only moves on a write aimed at this unit
  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.en |=> $stable(act));
endmodule

// File: rtl/gpio_pin_store.sv
`timescale 1ns/1ps
module gpio_pin_store
  import cfg_space_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_wr_t    wr,
  input  logic [7:0] rd_idx,
  output logic       rd_hit,
  output logic [7:0] rd_val
);
  localparam int PIN_W = $clog2(PINS);
  localparam int HI_W  = PIN_W - 3;

  logic [PIN_W-1:0] sel_q, sel_d;
  logic             sel_en;
  logic [7:0]       cfg_q [PINS];
  logic [7:0]       evt_q [PINS];
  logic [7:0]       sel_rb;

  always_comb begin
    sel_en = wr.en && (wr.idx == IDX_PIN_SEL);
    sel_d  = {wr.data[4 +: HI_W], wr.data[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic cfg_en, evt_en;
    always_comb begin
      cfg_en = wr.en && (wr.idx == IDX_PIN_CFG) && (sel_q == PIN_W'(p));
      evt_en = wr.en && (wr.idx == IDX_PIN_EVT) && (sel_q == PIN_W'(p));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[p] <= '0;
        evt_q[p] <= '0;
      end else begin
        if (cfg_en) cfg_q[p] <= wr.data;
        if (evt_en) evt_q[p] <= wr.data;
      end
    end
  end

  always_comb begin
    sel_rb             = '0;
    sel_rb[4 +: HI_W]  = sel_q[PIN_W-1:3];
    sel_rb[2:0]        = sel_q[2:0];
    rd_hit             = 1'b1;
    rd_val             = RD_EMPTY;
    case (rd_idx)
      IDX_PIN_SEL: rd_val = sel_rb;
      IDX_PIN_CFG: rd_val = cfg_q[sel_q];
      IDX_PIN_EVT: rd_val = evt_q[sel_q];
      default:     rd_hit = 1'b0;
    endcase
  end

  // R8: pin select changes only on a write to the GPIO bank
  p_pinsel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr.en |=> $stable(sel_q));
endmodule

// File: rtl/indexed_cfg_space.sv
`timescale 1ns/1ps
module indexed_cfg_space
  import cfg_space_pkg::*;
#(
  parameter bit                VARIANT_ALT = 1'b0,
  parameter int                PINS        = 32,
  parameter logic [ADDR_W-1:0] BASE_PRI    = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT    = 16'h004E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              chip_en,
  output logic              gpio_active,
  output logic [15:0]       gpio_base
);
  localparam logic [7:0] ID_CODE = VARIANT_ALT ? 8'hE9 : 8'hE5;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic hit_index, hit_data;
  cfg_port_decode #(.BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT)) u_decode (
    .io_addr   (io_addr),
    .strap_alt (strap_alt),
    .hit_index (hit_index),
    .hit_data  (hit_data)
  );

  logic [7:0] index_q, index_d, chipcfg_q, chipcfg_d, unit_q, unit_d, rdata_q, rdata_d;
  logic       index_en, chipcfg_en, unit_en, rdata_en;
  logic       wr_data, banked;
  logic [7:0] data_mux;

  logic [NUM_UNITS-1:0] unit_hit;
  logic [7:0]           unit_val [NUM_UNITS];
  logic [7:0]           unit_act [NUM_UNITS];
  logic [15:0]          unit_base[NUM_UNITS];
  logic                 pin_hit;
  logic [7:0]           pin_val;
  cfg_wr_t              pin_wr;

  always_comb begin
    wr_data = io_wr && hit_data;
    banked  = (index_q >= IDX_BANK_LO);
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    cfg_wr_t uwr;
    always_comb begin
      uwr.en   = wr_data && banked && (unit_q == unit_id(u));
      uwr.idx  = index_q;
      uwr.data = io_wdata;
    end
    cfg_unit_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr     (uwr),
      .rd_idx (index_q),
      .act    (unit_act[u]),
      .base   (unit_base[u]),
      .rd_hit (unit_hit[u]),
      .rd_val (unit_val[u])
    );
  end

  always_comb begin
    pin_wr.en   = wr_data && banked && (unit_q == unit_id(GPIO_SLOT));
    pin_wr.idx  = index_q;
    pin_wr.data = io_wdata;
  end

  gpio_pin_store #(.PINS(PINS)) u_pins (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (pin_wr),
    .rd_idx (index_q),
    .rd_hit (pin_hit),
    .rd_val (pin_val)
  );

  // data-port read mux
  always_comb begin
    data_mux = RD_EMPTY;
    if (!banked) begin
      case (index_q)
        IDX_UNIT_SEL: data_mux = unit_q;
        IDX_ID:       data_mux = ID_CODE;
        IDX_CHIPCFG:  data_mux = chipcfg_q;
        default:      data_mux = RD_EMPTY;
      endcase
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (unit_q == unit_id(u) && unit_hit[u]) data_mux = unit_val[u];
      end
      if (unit_q == unit_id(GPIO_SLOT) && pin_hit) data_mux = pin_val;
    end
  end

  // next state
  always_comb begin
    index_en   = io_wr && hit_index;
    index_d    = io_wdata;
    chipcfg_en = wr_data && (index_q == IDX_CHIPCFG);
    chipcfg_d  = io_wdata;
    unit_en    = wr_data && (index_q == IDX_UNIT_SEL);
    unit_d     = io_wdata;
    rdata_en   = io_rd && (hit_index || hit_data);
    rdata_d    = hit_index ? index_q : data_mux;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      index_q   <= '0;
      chipcfg_q <= CHIPCFG_RST;
      unit_q    <= '0;
      rdata_q   <= '0;
    end else begin
      if (index_en)   index_q   <= index_d;
      if (chipcfg_en) chipcfg_q <= chipcfg_d;
      if (unit_en)    unit_q    <= unit_d;
      if (rdata_en)   rdata_q   <= rdata_d;
    end
  end

  assign io_rdata    = rdata_q;
  assign chip_en     = chipcfg_q[0];
  assign gpio_active = |unit_act[GPIO_SLOT];
  assign gpio_base   = unit_base[GPIO_SLOT];

  // R2: index register holds unless the index port is written
  p_index_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(io_wr && hit_index) |=> $stable(index_q));
  // R3: identification read returns the fixed code
  p_id_read_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && hit_data && index_q == IDX_ID) |=> (io_rdata == ID_CODE));
  // R4: chip enable only moves on a data write at index 0x21
  p_chip_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_data && index_q == IDX_CHIPCFG) |=> $stable(chip_en));
  // R11: read data holds between accepted reads
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(io_rd && (hit_index || hit_data)) |=> $stable(io_rdata));
  // R10: an unimplemented unit selection reads as all ones
  p_empty_unit_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && hit_data && banked && unit_q == 8'h00) |=> (io_rdata == RD_EMPTY));
endmodule

// File: tb/test_indexed_cfg_space.sv
`timescale 1ns/1ps
module test_indexed_cfg_space;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        chip_en, gpio_active;
  logic [15:0] gpio_base;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  indexed_cfg_space i_indexed_cfg_space (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .chip_en(chip_en), .gpio_active(gpio_active), .gpio_base(gpio_base)
  );

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;
  logic [7:0] last_rd = 8'h00;
  logic [15:0] base = 16'h002E;

  always @(posedge clk) rd_seen <= io_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard: read with no expectation, got %02h", io_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (io_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata got %02h expected %02h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic cyc(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] i);
    cyc(base, 1'b1, 1'b0, i);
  endtask
  task automatic put(input logic [7:0] i, input logic [7:0] v);
    set_idx(i);
    cyc(base + 16'd1, 1'b1, 1'b0, v);
  endtask
  task automatic rd_at(input logic [15:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    last_rd = e;
    cyc(a, 1'b0, 1'b1, 8'h00);
  endtask
  task automatic get(input logic [7:0] i, input logic [7:0] e, input string t);
    set_idx(i);
    rd_at(base + 16'd1, e, t);
  endtask
  task automatic chk(input logic [15:0] got, input logic [15:0] e, input string t);
    n_checks++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: got %04h expected %04h", t, got, e);
    end
  endtask

  function automatic logic [7:0] pin_code(input int n);
    return 8'(((n << 1) & 8'hF0) | (n & 7));
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(16'(chip_en), 16'd1, "R4 reset chip_en");
    chk(16'(gpio_active), 16'd0, "R6 reset gpio_active");
    chk(gpio_base, 16'h0000, "R7 reset gpio_base");
    chk(16'(io_rdata), 16'h00, "R11 reset rdata");
    rd_at(base, 8'h00, "R2 reset index");

    // identification
    get(8'h20, 8'hE5, "R3 id read");
    cyc(base + 16'd1, 1'b1, 1'b0, 8'h12);
    rd_at(base + 16'd1, 8'hE5, "R3 id after write");
    rd_at(base, 8'h20, "R2 index readback");

    // chip configuration
    put(8'h21, 8'h00);
    chk(16'(chip_en), 16'd0, "R4 chip_en cleared");
    rd_at(base + 16'd1, 8'h00, "R4 cfg readback 00");
    put(8'h21, 8'h81);
    chk(16'(chip_en), 16'd1, "R4 chip_en set");
    rd_at(base + 16'd1, 8'h81, "R4 cfg readback 81");

    // unit select, empty unit 0
    get(8'h07, 8'h00, "R5 unit select reset");
    get(8'h30, 8'hFF, "R10 empty unit read");
    put(8'h30, 8'h05);
    put(8'h07, 8'h07);
    get(8'h07, 8'h07, "R5 unit select readback");
    get(8'h30, 8'h00, "R10 empty unit write ignored");

    // GPIO unit activate and base
    put(8'h30, 8'h01);
    chk(16'(gpio_active), 16'd1, "R6 gpio_active on");
    put(8'h60, 8'h12);
    put(8'h61, 8'h34);
    chk(gpio_base, 16'h1234, "R7 gpio_base");
    get(8'h60, 8'h12, "R7 base hi readback");
    get(8'h62, 8'hFF, "R10 missing banked index");

    // other unit is independent
    put(8'h07, 8'h0D);
    put(8'h60, 8'hAB);
    get(8'h60, 8'hAB, "R5 unit 0D base");
    get(8'h30, 8'h00, "R6 unit 0D activate reset");
    get(8'hF0, 8'hFF, "R10 pin select absent in unit 0D");
    chk(gpio_base, 16'h1234, "R5 gpio_base untouched by unit 0D");
    put(8'h30, 8'h00);
    chk(16'(gpio_active), 16'd1, "R6 gpio_active unaffected");
    put(8'h07, 8'h0E);
    get(8'h61, 8'h00, "R5 unit 0E base lo");
    put(8'h07, 8'h07);
    get(8'h60, 8'h12, "R5 back to GPIO unit");

    // per-pin storage
    put(8'hF0, pin_code(0));  put(8'hF1, 8'h11);
    put(8'hF0, pin_code(31)); put(8'hF1, 8'hA5); put(8'hF2, 8'h5A);
    put(8'hF0, pin_code(13)); put(8'hF1, 8'h3C);
    get(8'hF0, 8'h15, "R8 pin 13 select readback");
    put(8'hF0, pin_code(0));
    get(8'hF1, 8'h11, "R9 pin 0 cfg");
    get(8'hF2, 8'h00, "R9 pin 0 evt");
    put(8'hF0, pin_code(31));
    get(8'hF1, 8'hA5, "R9 pin 31 cfg");
    get(8'hF2, 8'h5A, "R9 pin 31 evt");
    put(8'hF0, pin_code(13));
    get(8'hF1, 8'h3C, "R9 pin 13 cfg");
    put(8'hF0, 8'hFF);
    get(8'hF0, 8'h37, "R8 masked pin select");
    get(8'hF1, 8'hA5, "R8 masked select reaches pin 31");

    // unimplemented global index
    get(8'h22, 8'hFF, "R10 empty global read");
    put(8'h22, 8'h00);
    chk(16'(chip_en), 16'd1, "R10 empty global write ignored");

    // address decode
    set_idx(8'h21);
    cyc(16'h004E, 1'b1, 1'b0, 8'h07);
    rd_at(base, 8'h21, "R1 alt index ignored");
    cyc(16'h004F, 1'b1, 1'b0, 8'h00);
    chk(16'(chip_en), 16'd1, "R1 alt data write ignored");
    cyc(16'h004F, 1'b0, 1'b1, 8'h00);
    exp_q.push_back(last_rd); tag_q.push_back("R1 alt read ignored");
    strap_alt = 1'b1;
    base = 16'h004E;
    rd_at(base, 8'h21, "R1 alt pair active");
    rd_at(base + 16'd1, 8'h81, "R1 alt data port");
    cyc(16'h002E, 1'b1, 1'b0, 8'h20);
    rd_at(base, 8'h21, "R1 primary ignored under strap");

    // hold behaviour
    repeat (5) @(negedge clk);
    chk(16'(io_rdata), 16'h21, "R11 rdata holds");

    repeat (3) @(negedge clk);
    chk(16'(exp_q.size()), 16'd0, "scoreboard drained");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule